// File: doc/BRIEF.md
# Program Counter Breakpoint Comparator

This block holds four instruction-address breakpoint registers. On every cycle it compares each of them with the address of the instruction the processor is running. A match raises a breakpoint hit. Software or a debug host loads the registers through a debug write port. That port carries an 8-bit register code and a 32-bit data word. The registers are write-only and no path reads them back.

Breakpoint register 0 has an associated mask register. Each mask bit set to 1 removes the matching address bit from the comparison, so register 0 can cover an address range. Registers 1 to 3 compare an exact address, and each is enabled by a valid flag held in bit 0 of its data word. The address space is 24 bits wide and instructions are 2-byte aligned, so the compare uses only address bits 23..1.

The per-register hit vector and the combined hit are registered once. They appear one cycle after a qualified program-counter sample. Comparison is enabled by a single input from the trigger-control logic.

Top module: `pc_bkpt_cmp`

## Requirements
- R1: While reset is high, and in the first cycle after it, `hit_vec` and `hit_any` are 0. Reset clears the valid flags of registers 1 to 3 and clears the mask register, so after reset registers 1 to 3 produce no hit.
- R2: A write with `wr_en`=1 loads the register selected by `wr_code`. Code 0x08 selects breakpoint register 0. Codes 0x18, 0x1A and 0x1C select registers 1, 2 and 3. Code 0x17 selects the mask. A write to any other code changes no register and no later hit.
- R3: When `pc_valid`=1, `pc_bp_en`=1 and register i matches `pc`, `hit_vec[i]` is 1 in the next cycle.
- R4: If `pc_valid`=0 or `pc_bp_en`=0 in a cycle, `hit_vec` and `hit_any` are 0 in the next cycle.
- R5: Registers 1 to 3 take their valid flag from bit 0 of the written data. A register whose flag is 0 never hits.
- R6: Address bit 0 and bits 31..24 of `pc` and of written addresses take no part in any comparison.
- R7: Register 0 hits when every address bit in 23..1 whose mask bit is 0 equals `pc`. A mask bit of 1 makes that bit a don't-care. The reset mask of all zeros requires an exact match.
- R8: The mask register has no effect on registers 1 to 3.
- R9: `hit_any` equals the OR of `hit_vec` in every cycle.
- R10: A register write first affects the compare of the `pc` sample taken in the cycle after the write. A sample taken in the write cycle uses the old contents.
- R11: Several registers can hit on the same `pc`, and every matching bit of `hit_vec` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Debug register write strobe |
| wr_code | input | 8 | Register code of the write |
| wr_data | input | 32 | Write data |
| pc_bp_en | input | 1 | Breakpoint compare enable from trigger control |
| pc_valid | input | 1 | `pc` holds a valid instruction address this cycle |
| pc | input | 32 | Current instruction address |
| hit_vec | output | 4 | Registered per-register hit, bit i for register i |
| hit_any | output | 1 | Registered OR of all hits |

## Verification
The hardest case to reach from the ports is a register write and a compare against the old contents of that register in the same cycle. The bench drives one edge with both a write to register 2 and a `pc` equal to its old address. It then checks that the old address hits and that the new address hits only from the next sample onward. A second hard case is the stuck state of a valid-cleared register. It is reached by loading register 3 with an address and bit 0 at 0. The bench then presents that exact address with the mask set wide, which confirms that neither the valid flag nor the mask opens a path.

// File: rtl/pc_bkpt_pkg.sv
package pc_bkpt_pkg;

    localparam int CODE_W    = 8;
    localparam int IDX_W     = 4;
    localparam logic [CODE_W-1:0] MASK_CODE = 8'h17;
    localparam logic [CODE_W-1:0] BP0_CODE  = 8'h08;
    localparam logic [CODE_W-1:0] BPN_BASE  = 8'h16;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_BP   = 2'd1,
        TGT_MASK = 2'd2
    } wr_tgt_e;

    typedef struct packed {
        wr_tgt_e          tgt;
        logic [IDX_W-1:0] idx;
    } wr_dec_t;

    // Code of breakpoint register i: register 0 is special, the rest step by 2.
    function automatic logic [CODE_W-1:0] bp_code(input int i);
        logic [CODE_W-1:0] c;
        if (i == 0) c = BP0_CODE;
        else        c = BPN_BASE + CODE_W'(2 * i);
        return c;
    endfunction

    function automatic wr_dec_t decode_code(input logic [CODE_W-1:0] code,
                                            input int nbp);
        wr_dec_t d;
        d.tgt = TGT_NONE;
        d.idx = '0;
        if (code == MASK_CODE) d.tgt = TGT_MASK;
        for (int i = 0; i < nbp; i++) begin
            if (code == bp_code(i)) begin
                d.tgt = TGT_BP;
                d.idx = IDX_W'(i);
            end
        end
        return d;
    endfunction

    // Masked equality over a field: a 1 in care_n removes that bit.
    function automatic logic field_match(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input logic [31:0] care_n);
        return &((~(a ^ b)) | care_n);
    endfunction

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import pc_bkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [CODE_W-1:0]              wr_code,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_BP-1:0][ADDR_W-1:1]  bp_addr,
    output logic [NUM_BP-1:0]              bp_valid,
    output logic [ADDR_W-1:1]              bp_mask
);
    wr_dec_t dec;
    logic [NUM_BP-1:0][ADDR_W-1:1] addr_q;
    logic [NUM_BP-1:0]             valid_q;
    logic [ADDR_W-1:1]             mask_q;
    logic                          unused_wr_bits;

    assign dec            = decode_code(wr_code, NUM_BP);
    assign unused_wr_bits = ^wr_data[DATA_W-1:ADDR_W];

    generate
        for (genvar i = 0; i < NUM_BP; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    addr_q[i]  <= '0;
                    valid_q[i] <= (i == 0);
                end else if (wr_en && dec.tgt == TGT_BP && dec.idx == IDX_W'(i)) begin
                    addr_q[i] <= wr_data[ADDR_W-1:1];
                    if (i != 0) valid_q[i] <= wr_data[0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                             mask_q <= '0;
        else if (wr_en && dec.tgt == TGT_MASK) mask_q <= wr_data[ADDR_W-1:1];
    end

    assign bp_addr  = addr_q;
    assign bp_valid = valid_q;
    assign bp_mask  = mask_q;

    // R1: valid flags of registers 1.. are clear right after reset
    assert_valid_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (valid_q[NUM_BP-1:1] == '0 && mask_q == '0));

    // R2: writes to unknown codes leave all state untouched
    assert_unknown_code_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.tgt == TGT_NONE) |=>
            ($stable(addr_q) && $stable(valid_q) && $stable(mask_q)));

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
    import pc_bkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]              pc,
    input  logic [NUM_BP-1:0][ADDR_W-1:1]  bp_addr,
    input  logic [NUM_BP-1:0]              bp_valid,
    input  logic [ADDR_W-1:1]              bp_mask,
    output logic [NUM_BP-1:0]              match_vec
);
    localparam int FW = ADDR_W - 1;

    logic [ADDR_W-1:1] pc_field;
    logic              unused_pc_bits;

    assign pc_field       = pc[ADDR_W-1:1];
    assign unused_pc_bits = ^{pc[DATA_W-1:ADDR_W], pc[0]};

    generate
        for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
            if (i == 0) begin : g_masked
                assign match_vec[i] = field_match(32'(pc_field), 32'(bp_addr[i]),
                                                  32'(bp_mask));
            end else begin : g_exact
                assign match_vec[i] = bp_valid[i] &
                    field_match(32'(pc_field), 32'(bp_addr[i]), 32'(0));
            end
        end
    endgenerate

    initial begin
        assert_width_R6: assert (FW >= 1 && FW < 32);
    end

endmodule

// File: rtl/bkpt_hit_reg.sv
module bkpt_hit_reg #(
    parameter int NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              qual,
    input  logic [NUM_BP-1:0] match_vec,
    output logic [NUM_BP-1:0] hit_vec,
    output logic              hit_any
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vec <= '0;
            hit_any <= 1'b0;
        end else begin
            hit_vec <= qual ? match_vec : '0;
            hit_any <= qual & (|match_vec);
        end
    end

    // R9: combined hit agrees with the vector
    assert_any_or_R9: assert property (@(posedge clk) disable iff (rst)
        hit_any == (|hit_vec));

    // R4: an unqualified sample never produces a hit
    assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !qual |=> (hit_vec == '0 && !hit_any));

endmodule

// File: rtl/pc_bkpt_cmp.sv
module pc_bkpt_cmp
    import pc_bkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_code,
    input  logic [31:0]       wr_data,
    input  logic              pc_bp_en,
    input  logic              pc_valid,
    input  logic [31:0]       pc,
    output logic [3:0]        hit_vec,
    output logic              hit_any
);
    logic [NUM_BP-1:0][ADDR_W-1:1] bp_addr;
    logic [NUM_BP-1:0]             bp_valid;
    logic [ADDR_W-1:1]             bp_mask;
    logic [NUM_BP-1:0]             match_vec;
    logic                          qual;

    assign qual = pc_valid & pc_bp_en;

    bkpt_regfile #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
        .bp_addr(bp_addr), .bp_valid(bp_valid), .bp_mask(bp_mask)
    );

    bkpt_match #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .pc(pc), .bp_addr(bp_addr), .bp_valid(bp_valid), .bp_mask(bp_mask),
        .match_vec(match_vec)
    );

    bkpt_hit_reg #(.NUM_BP(NUM_BP)) u_hit (
        .clk(clk), .rst(rst), .qual(qual), .match_vec(match_vec),
        .hit_vec(hit_vec), .hit_any(hit_any)
    );

    // R5: a register whose valid flag was clear cannot report a hit
    generate
        for (genvar i = 1; i < NUM_BP; i++) begin : g_vchk
            assert_invalid_nohit_R5: assert property (@(posedge clk) disable iff (rst)
                !bp_valid[i] |=> !hit_vec[i]);
        end
    endgenerate

    // R1: outputs quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (hit_vec == '0 && !hit_any));

endmodule

// File: tb/pc_bkpt_cmp_tb.sv
module pc_bkpt_cmp_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_code;
    logic [31:0] wr_data;
    logic        pc_bp_en;
    logic        pc_valid;
    logic [31:0] pc;
    logic [3:0]  hit_vec;
    logic        hit_any;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    pc_bkpt_cmp u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
        .pc_bp_en(pc_bp_en), .pc_valid(pc_valid), .pc(pc),
        .hit_vec(hit_vec), .hit_any(hit_any)
    );

    // entry: {pc[31:0], en, valid, expected hit[3:0], tag number}
    localparam int NV = 10;
    localparam logic [45:0] VEC [NV] = '{
        {32'h0000_1000, 1'b1, 1'b1, 4'b0001, 8'd3},
        {32'h0000_2000, 1'b1, 1'b1, 4'b0010, 8'd3},
        {32'h0000_3000, 1'b1, 1'b1, 4'b0100, 8'd3},
        {32'h0000_4000, 1'b1, 1'b1, 4'b0000, 8'd5},
        {32'h0000_1001, 1'b1, 1'b1, 4'b0001, 8'd6},
        {32'hFF00_2000, 1'b1, 1'b1, 4'b0010, 8'd6},
        {32'h0000_1000, 1'b0, 1'b1, 4'b0000, 8'd4},
        {32'h0000_2000, 1'b1, 1'b0, 4'b0000, 8'd4},
        {32'h0000_1002, 1'b1, 1'b1, 4'b0000, 8'd7},
        {32'h0000_5000, 1'b1, 1'b1, 4'b0000, 8'd3}
    };

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (hit_vec !== exp || hit_any !== (|exp)) begin
            failures++;
            $display("FAIL %s hit_vec=%b hit_any=%b expected hit_vec=%b hit_any=%b",
                     tag, hit_vec, hit_any, exp, |exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] code, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_code = code; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic en, input logic v,
                         input string tag, input logic [3:0] exp);
        @(negedge clk);
        pc = a; pc_bp_en = en; pc_valid = v;
        @(posedge clk); #1;
        check(tag, exp);
        @(negedge clk);
        pc_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; failures++;
                $display("FAIL watchdog expired actual=hung expected=done");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_code = '0; wr_data = '0;
        pc_bp_en = 1'b0; pc_valid = 1'b0; pc = '0;
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", 4'b0000);
        @(negedge clk); rst = 1'b0;
        // R1: regs 1..3 invalid after reset, reg0 cleared to address 0
        probe(32'h0000_2000, 1'b1, 1'b1, "R1 no hit after reset", 4'b0000);

        // R2: load through the documented codes
        write_reg(8'h08, 32'h0000_1000);
        write_reg(8'h18, 32'h0000_2001);
        write_reg(8'h1A, 32'h0000_3001);
        write_reg(8'h1C, 32'h0000_4000);

        for (int k = 0; k < NV; k++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VEC[k][7:0], k);
            probe(VEC[k][45:14], VEC[k][13], VEC[k][12], t, VEC[k][11:8]);
        end

        // R7: widen reg0 with a mask over bits 7..1
        write_reg(8'h17, 32'h0000_00FE);
        probe(32'h0000_10FE, 1'b1, 1'b1, "R7 masked bits ignored", 4'b0001);
        probe(32'h0000_1100, 1'b1, 1'b1, "R7 unmasked bit still compared", 4'b0000);
        // R8: mask does not widen the others
        probe(32'h0000_20FE, 1'b1, 1'b1, "R8 mask no effect on reg1", 4'b0000);

        // R2: unknown code changes nothing
        write_reg(8'h0A, 32'h0000_5001);
        probe(32'h0000_5000, 1'b1, 1'b1, "R2 unknown code ignored", 4'b0000);
        probe(32'h0000_3000, 1'b1, 1'b1, "R2 reg2 kept after unknown write", 4'b0100);

        // R5: reg3 with valid 0 stays silent even with wide mask
        write_reg(8'h17, 32'h00FF_FFFE);
        probe(32'h0000_4000, 1'b1, 1'b1, "R5 invalid reg3 under wide mask", 4'b0001);
        write_reg(8'h17, 32'h0000_0000);

        // R10: write and compare in the same cycle use old contents
        @(negedge clk);
        wr_en = 1'b1; wr_code = 8'h1A; wr_data = 32'h0000_6001;
        pc = 32'h0000_3000; pc_bp_en = 1'b1; pc_valid = 1'b1;
        @(posedge clk); #1;
        check("R10 old contents in write cycle", 4'b0100);
        @(negedge clk);
        wr_en = 1'b0; pc = 32'h0000_6000;
        @(posedge clk); #1;
        check("R10 new contents next cycle", 4'b0100);
        @(negedge clk); pc_valid = 1'b0;
        probe(32'h0000_3000, 1'b1, 1'b1, "R10 old address gone", 4'b0000);

        // R11 / R9: two registers on one address
        write_reg(8'h1C, 32'h0000_2001);
        probe(32'h0000_2000, 1'b1, 1'b1, "R11 multiple hits", 4'b1010);
        // R3: hit pulse lasts only for the qualified sample
        @(posedge clk); #1;
        check("R3 single-cycle pulse", 4'b0000);

        // R1: reset again clears valid flags
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        probe(32'h0000_2000, 1'b1, 1'b1, "R1 valid cleared by reset", 4'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule